// File: doc/BRIEF.md
# UART Interrupt Status and FIFO-Level Trigger Unit

This block produces the interrupt status of a UART. It looks at the fill counts of the transmit and receive FIFOs, the receive error pulses, a per-bit-period tick, a character-received strobe and the active-low clear-to-send line. From these it keeps an 8-bit raw status vector, a mask register, the masked status and one combined interrupt line. Software clears raw bits through a write-1-to-clear port and loads the mask through a write port. The FIFOs and the serial framing sit outside the block.

Each FIFO-level source runs a three-state machine. `LV_QUIET` means the condition holds but the bit was cleared, or the block has just left reset. `LV_ARMED` means the condition is false. `LV_PENDING` means the raw bit is set. The transitions are:
- QUIET→ARMED when the condition is false.
- ARMED→PENDING when the condition is true.
- PENDING→ARMED when the condition is false.
- PENDING→QUIET on a clear.

The receive-timeout machine has three states. `TO_OFF` means the source is disarmed or the receive FIFO is empty. `TO_RUN` means it is counting bit periods. `TO_HIT` means the raw bit is set. The transitions are:
- OFF→RUN when the source is armed and the FIFO is non-empty.
- RUN→OFF and HIT→OFF when the source is disarmed or the FIFO is empty.
- RUN→HIT on the terminal tick.
- HIT→RUN on a clear.

A separate gate blocks the receive DMA request while any raw error bit is set, if error gating is on.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `masked_status` is `raw_status` AND the mask register, and `irq` is the OR of `masked_status`. A mask write replaces the whole mask, and the result is visible after the next clock edge.
- R2: Status bit positions are: 0 CTS change, 1 receive level, 2 transmit level, 3 receive timeout, 4 framing, 5 parity, 6 break, 7 overrun.
- R3: With `fifo_on`=1, the transmit bit sets one cycle after `tx_count` moves from above the trigger level to at or below it. The bit drops one cycle after the count rises above the level.
- R4: With `fifo_on`=1, the receive bit sets one cycle after `rx_count` rises from below the trigger level to at or above it. The bit drops one cycle after the count falls below the level.
- R5: For DEPTH=16, the 3-bit trigger select codes 0, 1, 2, 3 and 4 give levels 2, 4, 8, 12 and 14 (DEPTH/8, /4, /2, 3/4, 7/8). The reserved codes 5 to 7 act as code 4.
- R6: With `fifo_on`=0, the transmit bit sets when `tx_count` becomes 0 and the receive bit sets when `rx_count` becomes non-zero. Each drops when its count changes back.
- R7: A clear write with bit k = 1 clears raw bit k after the next edge, and zero bits have no effect. A cleared level bit stays clear until its condition has gone false and true again.
- R8: The receive-timeout bit sets on the 32nd `bit_tick` after the FIFO turned non-empty or after the last `rx_char_done`. `rx_char_done` restarts the count.
- R9: The timeout bit clears when `rx_count` reaches 0, when mask bit 3 goes to 0, or on a clear. A clear restarts the count. The bit never sets while mask bit 3 is 0.
- R10: An error pulse sets its raw bit after the next edge. A pulse wins over a clear in the same cycle.
- R11: Any change of `cts_n` sets raw bit 0 after the next edge. The reference value resets to 1.
- R12: `rx_dma_req_out` equals `rx_dma_req_in`, except that it is forced to 0 when `dma_gate_on_err`=1 and any of raw bits 7 to 4 is set.
- R13: After reset, `raw_status`, `masked_status` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_on | input | 1 | 1: FIFO trigger levels apply; 0: single-slot rule |
| tx_level_sel | input | 3 | Transmit trigger select code |
| rx_level_sel | input | 3 | Receive trigger select code |
| tx_count | input | CNT_W (5) | Transmit FIFO fill count |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| rx_char_done | input | 1 | One-cycle strobe per received character |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| err_frame | input | 1 | Framing error pulse |
| err_parity | input | 1 | Parity error pulse |
| err_break | input | 1 | Break error pulse |
| err_overrun | input | 1 | Overrun error pulse |
| cts_n | input | 1 | Active-low clear-to-send, already synchronous |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask value |
| clr_we | input | 1 | Clear write strobe |
| clr_wdata | input | 8 | Write-1-to-clear bits |
| dma_gate_on_err | input | 1 | Block receive DMA while an error bit is set |
| rx_dma_req_in | input | 1 | Receive DMA request from the FIFO |
| rx_dma_req_out | output | 1 | Gated receive DMA request |
| raw_status | output | 8 | Raw status bits |
| masked_status | output | 8 | Masked status bits |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take several things for granted about the inputs:
- Error pulses, `bit_tick` and `rx_char_done` are clean synchronous strobes.
- `cts_n` is already synchronised to `clk`.
- The counts never exceed DEPTH.

The stimulus meets these conditions. It raises every strobe for exactly one cycle just after a rising edge and keeps the counts within 0 to 16. Before each level vector it parks the count at a value that makes the condition false, so the expected set cycle is known.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int IRQ_W   = 8;
    localparam int B_CTS   = 0;
    localparam int B_RXLV  = 1;
    localparam int B_TXLV  = 2;
    localparam int B_RXTO  = 3;
    localparam int B_FRAME = 4;
    localparam int B_PAR   = 5;
    localparam int B_BRK   = 6;
    localparam int B_OVR   = 7;
    localparam int N_ERR   = 4;

    typedef enum logic [1:0] {
        LV_QUIET   = 2'd0,
        LV_ARMED   = 2'd1,
        LV_PENDING = 2'd2
    } lv_state_t;

    typedef enum logic [1:0] {
        TO_OFF = 2'd0,
        TO_RUN = 2'd1,
        TO_HIT = 2'd2
    } to_state_t;

    // trigger level in entries for a select code; reserved codes use the top level
    function automatic int unsigned trig_level(input logic [2:0] code, input int unsigned depth);
        unique case (code)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd2:    return depth / 2;
            3'd3:    return (depth * 3) / 4;
            default: return (depth * 7) / 8;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter bit IS_TX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_on,
    input  logic [2:0]       sel,
    input  logic [CNT_W-1:0] count,
    input  logic             clr,
    output logic             pend
);
    lv_state_t        state_q, state_d;
    logic [CNT_W-1:0] lvl;
    logic             cond;

    assign lvl = CNT_W'(trig_level(sel, DEPTH));

    generate
        if (IS_TX) begin : g_tx
            assign cond = fifo_on ? (count <= lvl) : (count == '0);
        end else begin : g_rx
            assign cond = fifo_on ? (count >= lvl) : (count != '0);
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_QUIET:   if (!cond) state_d = LV_ARMED;
            LV_ARMED:   if (cond)  state_d = LV_PENDING;
            LV_PENDING: begin
                if (!cond)    state_d = LV_ARMED;
                else if (clr) state_d = LV_QUIET;
            end
            default:    state_d = LV_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == LV_PENDING);
    end

    // R7: a clear on a pending source drops it at the next edge
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr) |=> !pend);
    // R3 / R4: losing the condition releases the bit
    a_r3_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cond) |=> !pend);
    // R3 / R4: a bit only rises while its condition held on the previous cycle
    a_r4_rise_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(cond));
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
    import uart_irq_pkg::*;
#(
    parameter int TO_BITS = 32,
    parameter int TC_W    = $clog2(TO_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rx_nonempty,
    input  logic rx_char,
    input  logic tick,
    input  logic clr,
    output logic hit
);
    localparam logic [TC_W-1:0] LAST = TC_W'(TO_BITS - 1);

    to_state_t       state_q, state_d;
    logic [TC_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TO_OFF: begin
                cnt_d = '0;
                if (arm && rx_nonempty) state_d = TO_RUN;
            end
            TO_RUN: begin
                if (!arm || !rx_nonempty) begin
                    state_d = TO_OFF;
                    cnt_d   = '0;
                end else if (rx_char) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = TO_HIT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TO_HIT: begin
                if (!arm || !rx_nonempty) state_d = TO_OFF;
                else if (clr)             state_d = TO_RUN;
                cnt_d = '0;
            end
            default: begin
                state_d = TO_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        hit = (state_q == TO_HIT);
    end

    // R8: the timeout can only fire on a bit-period tick
    a_r8_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(tick));
    // R9: an empty FIFO ends the timeout at the next edge
    a_r9_empty_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !rx_nonempty) |=> !hit);
    // R8: the counter never passes the terminal value
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TO_BITS = 32,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_on,
    input  logic [2:0]       tx_level_sel,
    input  logic [2:0]       rx_level_sel,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_char_done,
    input  logic             bit_tick,
    input  logic             err_frame,
    input  logic             err_parity,
    input  logic             err_break,
    input  logic             err_overrun,
    input  logic             cts_n,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wdata,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_wdata,
    input  logic             dma_gate_on_err,
    input  logic             rx_dma_req_in,
    output logic             rx_dma_req_out,
    output logic [IRQ_W-1:0] raw_status,
    output logic [IRQ_W-1:0] masked_status,
    output logic             irq
);
    logic [IRQ_W-1:0] mask_q, mask_d, clr_hit;
    logic [N_ERR-1:0] err_in, err_q;
    logic             cts_ref_q, cts_raw_q;
    logic             tx_pend, rx_pend, to_hit;

    assign clr_hit = clr_we ? clr_wdata : '0;
    assign mask_d  = mask_we ? mask_wdata : mask_q;
    assign err_in  = {err_overrun, err_break, err_parity, err_frame};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    uart_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_txlv (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .sel(tx_level_sel),
        .count(tx_count), .clr(clr_hit[B_TXLV]), .pend(tx_pend));

    uart_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rxlv (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .sel(rx_level_sel),
        .count(rx_count), .clr(clr_hit[B_RXLV]), .pend(rx_pend));

    uart_irq_timeout #(.TO_BITS(TO_BITS)) u_to (
        .clk(clk), .rst_n(rst_n), .arm(mask_d[B_RXTO]),
        .rx_nonempty(rx_count != '0), .rx_char(rx_char_done),
        .tick(bit_tick), .clr(clr_hit[B_RXTO]), .hit(to_hit));

    genvar gi;
    generate
        for (gi = 0; gi < N_ERR; gi++) begin : g_err
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    err_q[gi] <= 1'b0;
                else if (err_in[gi])           err_q[gi] <= 1'b1;
                else if (clr_hit[B_FRAME + gi]) err_q[gi] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_ref_q <= 1'b1;
            cts_raw_q <= 1'b0;
        end else begin
            cts_ref_q <= cts_n;
            if (cts_n != cts_ref_q)  cts_raw_q <= 1'b1;
            else if (clr_hit[B_CTS]) cts_raw_q <= 1'b0;
        end
    end

    always_comb begin
        raw_status          = '0;
        raw_status[B_CTS]   = cts_raw_q;
        raw_status[B_RXLV]  = rx_pend;
        raw_status[B_TXLV]  = tx_pend;
        raw_status[B_RXTO]  = to_hit;
        raw_status[B_OVR:B_FRAME] = err_q;
        masked_status  = raw_status & mask_q;
        irq            = |masked_status;
        rx_dma_req_out = rx_dma_req_in & ~(dma_gate_on_err & (|err_q));
    end

    // R10: an error pulse always lands in its raw bit
    a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> raw_status[B_FRAME]);
    // R7: clearing a parity error without a new pulse removes it
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_wdata[B_PAR] && !err_parity) |=> !raw_status[B_PAR]);
    // R9: the timeout bit is never set while its mask bit is off
    a_r9_to_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        raw_status[B_RXTO] |-> mask_q[B_RXTO]);
    // R11: a CTS change is recorded
    a_r11_cts_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_n != $past(cts_n)) |=> raw_status[B_CTS]);
    // R12: gated DMA never passes while an error bit is set
    a_r12_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gate_on_err && (|raw_status[B_OVR:B_FRAME])) |-> !rx_dma_req_out);
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_on = 1'b0;
    logic [2:0]    tx_level_sel = 3'd2, rx_level_sel = 3'd2;
    logic [CW-1:0] tx_count = '0, rx_count = '0;
    logic          rx_char_done = 1'b0, bit_tick = 1'b0;
    logic          err_frame = 1'b0, err_parity = 1'b0, err_break = 1'b0, err_overrun = 1'b0;
    logic          cts_n = 1'b1;
    logic          mask_we = 1'b0, clr_we = 1'b0;
    logic [7:0]    mask_wdata = '0, clr_wdata = '0;
    logic          dma_gate_on_err = 1'b0, rx_dma_req_in = 1'b0;
    logic          rx_dma_req_out, irq;
    logic [7:0]    raw_status, masked_status;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on),
        .tx_level_sel(tx_level_sel), .rx_level_sel(rx_level_sel),
        .tx_count(tx_count), .rx_count(rx_count),
        .rx_char_done(rx_char_done), .bit_tick(bit_tick),
        .err_frame(err_frame), .err_parity(err_parity),
        .err_break(err_break), .err_overrun(err_overrun),
        .cts_n(cts_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .dma_gate_on_err(dma_gate_on_err), .rx_dma_req_in(rx_dma_req_in),
        .rx_dma_req_out(rx_dma_req_out), .raw_status(raw_status),
        .masked_status(masked_status), .irq(irq));

    // vector: [10] tx, [9] fifo_on, [8:6] select, [5:1] count, [0] expected bit
    localparam int NV = 20;
    localparam logic [10:0] VEC [0:NV-1] = '{
        {1'b1, 1'b1, 3'd2, 5'd8,  1'b1}, {1'b1, 1'b1, 3'd2, 5'd9,  1'b0},
        {1'b1, 1'b1, 3'd0, 5'd2,  1'b1}, {1'b1, 1'b1, 3'd0, 5'd3,  1'b0},
        {1'b1, 1'b1, 3'd4, 5'd14, 1'b1}, {1'b1, 1'b1, 3'd4, 5'd15, 1'b0},
        {1'b1, 1'b1, 3'd7, 5'd14, 1'b1}, {1'b1, 1'b1, 3'd6, 5'd15, 1'b0},
        {1'b1, 1'b0, 3'd2, 5'd0,  1'b1}, {1'b1, 1'b0, 3'd2, 5'd1,  1'b0},
        {1'b0, 1'b1, 3'd2, 5'd8,  1'b1}, {1'b0, 1'b1, 3'd2, 5'd7,  1'b0},
        {1'b0, 1'b1, 3'd1, 5'd4,  1'b1}, {1'b0, 1'b1, 3'd1, 5'd3,  1'b0},
        {1'b0, 1'b1, 3'd3, 5'd12, 1'b1}, {1'b0, 1'b1, 3'd3, 5'd11, 1'b0},
        {1'b0, 1'b1, 3'd5, 5'd14, 1'b1}, {1'b0, 1'b1, 3'd5, 5'd13, 1'b0},
        {1'b0, 1'b0, 3'd2, 5'd1,  1'b1}, {1'b0, 1'b0, 3'd2, 5'd16, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step(1);
            bit_tick = 1'b0;
        end
    endtask

    task automatic clear(input logic [7:0] v);
        clr_we = 1'b1;
        clr_wdata = v;
        step(1);
        clr_we = 1'b0;
        clr_wdata = '0;
    endtask

    task automatic set_mask(input logic [7:0] v);
        mask_we = 1'b1;
        mask_wdata = v;
        step(1);
        mask_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        step(3);
        rst_n = 1'b1;
        step(1);
        // R13 reset state
        chk("R13 raw", raw_status, 8'h00);
        chk("R13 masked", masked_status, 8'h00);
        chk("R13 irq", irq, 1'b0);

        // R3 R4 R5 R6 level vectors
        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VEC[i];
            fifo_on = v[9];
            if (v[10]) begin
                tx_level_sel = v[8:6];
                tx_count = 5'd16;
            end else begin
                rx_level_sel = v[8:6];
                rx_count = 5'd0;
            end
            step(2);
            if (v[10]) tx_count = v[5:1];
            else       rx_count = v[5:1];
            step(1);
            chk(v[10] ? "R3/R5/R6 tx level (bit 2)" : "R4/R5/R6 rx level (bit 1)",
                v[10] ? raw_status[2] : raw_status[1], v[0]);
        end
        rx_count = 5'd0;
        step(2);

        // R1 mask and combined line
        fifo_on = 1'b1;
        tx_level_sel = 3'd2;
        tx_count = 5'd16;
        step(2);
        tx_count = 5'd4;
        step(1);
        chk("R3 tx pending", raw_status, 8'h04);
        chk("R1 irq masked off", irq, 1'b0);
        set_mask(8'h04);
        chk("R1 masked", masked_status, 8'h04);
        chk("R1 irq on", irq, 1'b1);
        set_mask(8'h00);
        chk("R1 irq after unmask", irq, 1'b0);

        // R7 write-1-to-clear
        clear(8'h00);
        chk("R7 zero write no effect", raw_status[2], 1'b1);
        clear(8'h04);
        chk("R7 tx cleared", raw_status[2], 1'b0);
        step(3);
        chk("R7 stays clear", raw_status[2], 1'b0);
        tx_count = 5'd16;
        step(2);
        tx_count = 5'd4;
        step(1);
        chk("R7 rearm after condition cycle", raw_status[2], 1'b1);
        tx_count = 5'd16;
        step(2);

        // R10 errors and R2 positions
        err_frame = 1'b1;
        step(1);
        err_frame = 1'b0;
        chk("R10 R2 framing at bit 4", raw_status, 8'h10);
        err_parity = 1'b1;
        clr_we = 1'b1;
        clr_wdata = 8'h20;
        step(1);
        err_parity = 1'b0;
        clr_we = 1'b0;
        chk("R10 pulse beats clear", raw_status, 8'h30);
        err_break = 1'b1;
        step(1);
        err_break = 1'b0;
        chk("R2 break at bit 6", raw_status, 8'h70);
        clear(8'h70);
        chk("R7 errors cleared", raw_status, 8'h00);

        // R12 DMA gate
        rx_dma_req_in = 1'b1;
        dma_gate_on_err = 1'b1;
        #1;
        chk("R12 no error passes", rx_dma_req_out, 1'b1);
        err_overrun = 1'b1;
        step(1);
        err_overrun = 1'b0;
        chk("R2 overrun at bit 7", raw_status, 8'h80);
        chk("R12 blocked", rx_dma_req_out, 1'b0);
        dma_gate_on_err = 1'b0;
        #1;
        chk("R12 gate off passes", rx_dma_req_out, 1'b1);
        clear(8'h80);
        rx_dma_req_in = 1'b0;

        // R11 CTS change
        cts_n = 1'b0;
        step(1);
        chk("R11 cts change", raw_status, 8'h01);
        clear(8'h01);
        chk("R11 cleared", raw_status[0], 1'b0);
        cts_n = 1'b1;
        step(1);
        chk("R11 release edge", raw_status[0], 1'b1);
        clear(8'h01);

        // R8 R9 receive timeout
        fifo_on = 1'b0;
        set_mask(8'h08);
        rx_count = 5'd1;
        step(2);
        clear(8'h02);
        ticks(31);
        chk("R8 not yet at 31", raw_status[3], 1'b0);
        ticks(1);
        chk("R8 fires at 32", raw_status[3], 1'b1);
        chk("R1 timeout masked", irq, 1'b1);
        clear(8'h08);
        chk("R9 clear", raw_status[3], 1'b0);
        ticks(20);
        rx_char_done = 1'b1;
        step(1);
        rx_char_done = 1'b0;
        ticks(31);
        chk("R8 char restarts count", raw_status[3], 1'b0);
        ticks(1);
        chk("R8 fires after restart", raw_status[3], 1'b1);
        rx_count = 5'd0;
        step(1);
        chk("R9 empty clears", raw_status[3], 1'b0);
        rx_count = 5'd1;
        step(2);
        ticks(32);
        chk("R8 fires again", raw_status[3], 1'b1);
        set_mask(8'h00);
        chk("R9 mask off clears", raw_status[3], 1'b0);
        ticks(40);
        chk("R9 no set while masked", raw_status[3], 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule